// File: doc/BRIEF.md
# Dual TAP Test Port with Ownership Switchover

This block is the front end of a chip's JTAG test access port. One pin set (TCK, TMS, TDI, TDO and an active-low TRST) is shared by two independent TAP state machines. A boundary-scan TAP handles device identification, boundary sampling and external pin testing. A debug TAP sends single-cycle reset and interrupt requests to the core. All pins are sampled in the system clock domain through a synchronizer, so TCK must run well below that clock: each TCK phase must last at least three system clock cycles.

After TRST is pulled low, the boundary-scan TAP owns the port. A dedicated switchover instruction, loaded into the boundary-scan TAP, hands TMS, TDI and TDO to the debug TAP at that TAP's update step. From then on, nothing sent over TMS can give the port back. Only another TRST assertion returns it to the boundary-scan TAP.

Top module: `dual_tap_port`

## Requirements
- R1: While the synchronized TRST is low, both TAPs are held in Test-Logic-Reset, the boundary-scan TAP owns the port, TDO is not enabled, both request outputs are 0, the boundary update latch is cleared, and the boundary drive output is 0.
- R2: Each TAP follows the standard 16-state TAP state machine and advances on rising TCK according to TMS. Five consecutive TMS=1 clocks reach Test-Logic-Reset from any state.
- R3: TDO changes only after a falling TCK edge. tdoOe is 1 only while the owning TAP is in Shift-IR or Shift-DR.
- R4: The instruction register is 8 bits wide and is shifted least significant bit first. Capture-IR loads 8'h01. The new instruction takes effect on the rising TCK edge that leaves Update-IR.
- R5: Test-Logic-Reset selects the IDCODE instruction (8'h10). The IDCODE data register holds 32 bits with bit 0 forced to 1, is loaded in Capture-DR, and is shifted out least significant bit first.
- R6: BYPASS (8'hFF) and every undefined code select a 1-bit register that captures 0. Shifting N bits through it returns 0 followed by the first N-1 input bits.
- R7: SAMPLE/PRELOAD (8'h20) captures the pin inputs into the boundary register. At Update-DR it loads the update latch without raising the drive output.
- R8: EXTEST (8'h00) raises bsDrive. The value shifted into the boundary register appears on bsPinOut at Update-DR.
- R9: The switchover instruction (8'h5A) passes ownership to the debug TAP on the edge that leaves Update-IR. Afterwards the boundary-scan TAP stays in Test-Logic-Reset and cannot be reached, including after five TMS=1 clocks.
- R10: The debug TAP has its own 8-bit instruction register that captures 8'h01. Updating code 8'h31 pulses coreResetReq for one clock, and updating 8'h32 pulses coreIntReq for one clock. Every debug data scan uses a 1-bit bypass register that captures 0.
- R11: When TRST falls in the same system clock cycle that TCK rises out of a debug Update-IR, the reset wins: no request pulse is produced, and the boundary-scan TAP owns the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the port pins |
| rstN | input | 1 | Asynchronous system reset, active low |
| tck | input | 1 | Test clock pin |
| tms | input | 1 | Test mode select pin |
| tdi | input | 1 | Test data in pin |
| trstN | input | 1 | Test reset pin, active low |
| tdo | output | 1 | Test data out |
| tdoOe | output | 1 | Output enable for tdo |
| bsPinIn | input | BSR_LEN | Values observed at the boundary pins |
| bsPinOut | output | BSR_LEN | Boundary update latch contents |
| bsDrive | output | 1 | Boundary latch drives the pins (EXTEST active) |
| coreResetReq | output | 1 | One-cycle reset request to the core |
| coreIntReq | output | 1 | One-cycle interrupt request to the core |

## Verification
Two events can land in the same system clock cycle. The first is TRST reset. The second is the rising TCK edge that leaves the debug TAP's Update-IR, which is the edge that would fire a core request. The bench provokes this by driving trstN low at the same instant as that TCK rise. Both pins pass through one synchronizer word, so they arrive together. The bench then counts coreResetReq pulses to confirm that none appeared. Finally it reads IDCODE to confirm that the boundary-scan TAP owns the port again.

// File: rtl/dtap_pkg.sv
package dtap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PAUDR, ST_EX2DR, ST_UPDDR,
    ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PAUIR, ST_EX2IR, ST_UPDIR
  } tapState_e;

  // Strobes from control to datapath; edge strobes are qualified by a TCK rise.
  typedef struct packed {
    logic bsCapIr;
    logic bsShIr;
    logic bsUpdIr;
    logic bsCapDr;
    logic bsShDr;
    logic bsUpdDr;
    logic bsReset;
    logic dbCapIr;
    logic dbShIr;
    logic dbUpdIr;
    logic dbCapDr;
    logic dbShDr;
    logic fall;
    logic inShIr;
    logic inShDr;
    logic dbgOwner;
  } strobe_t;

  function automatic tapState_e tapNext(input tapState_e s, input logic m);
    tapState_e n;
    case (s)
      ST_RESET: n = m ? ST_RESET : ST_IDLE;
      ST_IDLE:  n = m ? ST_SELDR : ST_IDLE;
      ST_SELDR: n = m ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: n = m ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  n = m ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: n = m ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: n = m ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: n = m ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: n = m ? ST_SELDR : ST_IDLE;
      ST_SELIR: n = m ? ST_RESET : ST_CAPIR;
      ST_CAPIR: n = m ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  n = m ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: n = m ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: n = m ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: n = m ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: n = m ? ST_SELDR : ST_IDLE;
      default:  n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dtap_fsm.sv
module dtap_fsm
  import dtap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hold,
  input  logic      step,
  input  logic      tms,
  output tapState_e state
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      state <= ST_RESET;
    else if (hold)  state <= ST_RESET;
    else if (step)  state <= tapNext(state, tms);
  end

  // Checker counter: consecutive TMS=1 steps since the last TMS=0 step.
  logic [2:0] onesCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    onesCnt <= 3'd5;
    else if (hold)                onesCnt <= 3'd5;
    else if (step && !tms)        onesCnt <= 3'd0;
    else if (step && onesCnt < 5) onesCnt <= onesCnt + 3'd1;
  end

  assert_five_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    (onesCnt == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/dtap_ctrl.sv
module dtap_ctrl
  import dtap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tckPin,
  input  logic    tmsPin,
  input  logic    tdiPin,
  input  logic    trstNPin,
  input  logic    switchHit,
  output strobe_t st,
  output logic    tdiS,
  output logic    tapRst
);

  localparam int LAST = SYNC_STAGES - 1;

  // One synchronizer word carries all four pins so they stay aligned.
  logic [3:0] syncQ [SYNC_STAGES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= 4'b0000;
    end else begin
      syncQ[0] <= {trstNPin, tdiPin, tmsPin, tckPin};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  logic tckS, tmsS, trstS, tckD;
  assign tckS  = syncQ[LAST][0];
  assign tmsS  = syncQ[LAST][1];
  assign tdiS  = syncQ[LAST][2];
  assign trstS = syncQ[LAST][3];
  assign tapRst = !trstS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tckD <= 1'b0;
    else       tckD <= tckS;
  end

  logic rise, fall;
  assign rise = tckS && !tckD;
  assign fall = !tckS && tckD;

  logic owner;
  tapState_e bsState, dbState;

  dtap_fsm u_bsFsm (
    .clk(clk), .rstN(rstN), .hold(tapRst || owner),
    .step(rise), .tms(tmsS), .state(bsState)
  );

  dtap_fsm u_dbFsm (
    .clk(clk), .rstN(rstN), .hold(tapRst || !owner),
    .step(rise), .tms(tmsS), .state(dbState)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        owner <= 1'b0;
    else if (tapRst)  owner <= 1'b0;
    else if (rise && !owner && bsState == ST_UPDIR && switchHit) owner <= 1'b1;
  end

  always_comb begin
    st.bsCapIr  = rise && bsState == ST_CAPIR;
    st.bsShIr   = rise && bsState == ST_SHIR;
    st.bsUpdIr  = rise && bsState == ST_UPDIR;
    st.bsCapDr  = rise && bsState == ST_CAPDR;
    st.bsShDr   = rise && bsState == ST_SHDR;
    st.bsUpdDr  = rise && bsState == ST_UPDDR;
    st.bsReset  = bsState == ST_RESET;
    st.dbCapIr  = rise && dbState == ST_CAPIR;
    st.dbShIr   = rise && dbState == ST_SHIR;
    st.dbUpdIr  = rise && dbState == ST_UPDIR;
    st.dbCapDr  = rise && dbState == ST_CAPDR;
    st.dbShDr   = rise && dbState == ST_SHDR;
    st.fall     = fall;
    st.inShIr   = owner ? (dbState == ST_SHIR) : (bsState == ST_SHIR);
    st.inShDr   = owner ? (dbState == ST_SHDR) : (bsState == ST_SHDR);
    st.dbgOwner = owner;
  end

  assert_owner_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (owner && !tapRst) |=> owner);

  assert_trst_reclaims_R1: assert property (@(posedge clk) disable iff (!rstN)
    tapRst |=> !owner);

  assert_bs_parked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (owner && $past(owner)) |-> (bsState == ST_RESET));

endmodule

// File: rtl/dtap_dp.sv
module dtap_dp
  import dtap_pkg::*;
#(
  parameter int          IR_W       = 8,
  parameter int          BSR_LEN    = 8,
  parameter logic [31:0] ID_VALUE   = 32'h1A2B_3C4D,
  parameter logic [7:0]  OP_EXTEST  = 8'h00,
  parameter logic [7:0]  OP_IDCODE  = 8'h10,
  parameter logic [7:0]  OP_SAMPLE  = 8'h20,
  parameter logic [7:0]  OP_SWITCH  = 8'h5A,
  parameter logic [7:0]  OP_DBGRST  = 8'h31,
  parameter logic [7:0]  OP_DBGINT  = 8'h32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tapRst,
  input  strobe_t            st,
  input  logic               tdiS,
  input  logic [BSR_LEN-1:0] bsPinIn,
  output logic               switchHit,
  output logic               tdo,
  output logic               tdoOe,
  output logic [BSR_LEN-1:0] bsPinOut,
  output logic               bsDrive,
  output logic               resetReq,
  output logic               intReq
);

  localparam logic [IR_W-1:0] IR_CAP   = {{(IR_W-2){1'b0}}, 2'b01};
  localparam logic [31:0]     ID_FIXED = {ID_VALUE[31:1], 1'b1};

  // Boundary-scan TAP registers
  logic [IR_W-1:0]    bsIrSh, bsIr;
  logic [31:0]        idSh;
  logic               bsByp;
  logic [BSR_LEN-1:0] bsrSh, bsrUpd;
  logic               selId, selBsr;

  assign selId     = (bsIr == OP_IDCODE);
  assign selBsr    = (bsIr == OP_EXTEST) || (bsIr == OP_SAMPLE);
  assign switchHit = (bsIrSh == OP_SWITCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bsIrSh <= IR_CAP;
      bsIr   <= OP_IDCODE;
    end else if (tapRst || st.bsReset) begin
      bsIr   <= OP_IDCODE;
    end else begin
      if (st.bsCapIr)     bsIrSh <= IR_CAP;
      else if (st.bsShIr) bsIrSh <= {tdiS, bsIrSh[IR_W-1:1]};
      if (st.bsUpdIr)     bsIr   <= bsIrSh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idSh  <= ID_FIXED;
      bsByp <= 1'b0;
      bsrSh <= '0;
    end else begin
      if (st.bsCapDr && selId)      idSh <= ID_FIXED;
      else if (st.bsShDr && selId)  idSh <= {tdiS, idSh[31:1]};
      if (st.bsCapDr && !selId && !selBsr)     bsByp <= 1'b0;
      else if (st.bsShDr && !selId && !selBsr) bsByp <= tdiS;
      if (st.bsCapDr && selBsr)     bsrSh <= bsPinIn;
      else if (st.bsShDr && selBsr) bsrSh <= {tdiS, bsrSh[BSR_LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       bsrUpd <= '0;
    else if (tapRst)                 bsrUpd <= '0;
    else if (st.bsUpdDr && selBsr)   bsrUpd <= bsrSh;
  end

  assign bsPinOut = bsrUpd;
  assign bsDrive  = (bsIr == OP_EXTEST) && !st.dbgOwner;

  // Debug TAP registers
  logic [IR_W-1:0] dbIrSh;
  logic            dbByp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbIrSh <= IR_CAP;
      dbByp  <= 1'b0;
    end else begin
      if (st.dbCapIr)     dbIrSh <= IR_CAP;
      else if (st.dbShIr) dbIrSh <= {tdiS, dbIrSh[IR_W-1:1]};
      if (st.dbCapDr)     dbByp  <= 1'b0;
      else if (st.dbShDr) dbByp  <= tdiS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq <= 1'b0;
      intReq   <= 1'b0;
    end else if (tapRst) begin
      resetReq <= 1'b0;
      intReq   <= 1'b0;
    end else begin
      resetReq <= st.dbUpdIr && (dbIrSh == OP_DBGRST);
      intReq   <= st.dbUpdIr && (dbIrSh == OP_DBGINT);
    end
  end

  // TDO path, updated on falling TCK only
  logic tdoNext, tdoReg;
  always_comb begin
    if (st.inShIr)         tdoNext = st.dbgOwner ? dbIrSh[0] : bsIrSh[0];
    else if (st.dbgOwner)  tdoNext = dbByp;
    else if (selId)        tdoNext = idSh[0];
    else if (selBsr)       tdoNext = bsrSh[0];
    else                   tdoNext = bsByp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tdoReg <= 1'b0;
    else if (st.fall) tdoReg <= tdoNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tdoOe <= 1'b0;
    else if (tapRst)  tdoOe <= 1'b0;
    else if (st.fall) tdoOe <= st.inShIr || st.inShDr;
  end

  assign tdo = tdoReg;

  assert_tdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !st.fall |=> $stable(tdoReg));

  assert_ir_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.bsCapIr && !tapRst) |=> (bsIrSh == IR_CAP));

  assert_extest_update_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.bsUpdDr && selBsr && !tapRst) |=> (bsPinOut == $past(bsrSh)));

  assert_switch_parks_ir_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.dbgOwner && $past(st.dbgOwner)) |=> (bsIr == OP_IDCODE));

  assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_int_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    intReq |=> !intReq);

  assert_trst_no_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    tapRst |=> (!resetReq && !intReq));

endmodule

// File: rtl/dual_tap_port.sv
module dual_tap_port
  import dtap_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          BSR_LEN     = 8,
  parameter logic [31:0] ID_VALUE    = 32'h1A2B_3C4D
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  input  logic               trstN,
  output logic               tdo,
  output logic               tdoOe,
  input  logic [BSR_LEN-1:0] bsPinIn,
  output logic [BSR_LEN-1:0] bsPinOut,
  output logic               bsDrive,
  output logic               coreResetReq,
  output logic               coreIntReq
);

  strobe_t st;
  logic    tdiS, tapRst, switchHit;

  dtap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tckPin(tck), .tmsPin(tms), .tdiPin(tdi),
    .trstNPin(trstN), .switchHit(switchHit), .st(st), .tdiS(tdiS),
    .tapRst(tapRst)
  );

  dtap_dp #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .tapRst(tapRst), .st(st), .tdiS(tdiS),
    .bsPinIn(bsPinIn), .switchHit(switchHit), .tdo(tdo), .tdoOe(tdoOe),
    .bsPinOut(bsPinOut), .bsDrive(bsDrive), .resetReq(coreResetReq),
    .intReq(coreIntReq)
  );

endmodule

// File: tb/sim_dual_tap_port.sv
module sim_dual_tap_port;

  localparam int          BSR_LEN = 8;
  localparam logic [31:0] ID_EXP  = 32'h1A2B_3C4D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tck = 1'b1, tms = 1'b1, tdi = 1'b0, trstN = 1'b0;
  logic [BSR_LEN-1:0] bsPinIn = '0;
  logic tdo, tdoOe, bsDrive, coreResetReq, coreIntReq;
  logic [BSR_LEN-1:0] bsPinOut;

  always #4 clk = !clk;

  dual_tap_port #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_EXP)) u0 (
    .clk(clk), .rstN(rstN), .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .tdo(tdo), .tdoOe(tdoOe), .bsPinIn(bsPinIn), .bsPinOut(bsPinOut),
    .bsDrive(bsDrive), .coreResetReq(coreResetReq), .coreIntReq(coreIntReq)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  int rstPulses = 0, intPulses = 0;

  always @(posedge clk) begin
    if (coreResetReq) rstPulses++;
    if (coreIntReq)   intPulses++;
  end

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t expQ[$];
  logic [31:0] gotQ[$];

  task automatic expectScan(input string tag, input logic [31:0] v);
    item_t it;
    it.tag = tag; it.val = v;
    expQ.push_back(it);
  endtask

  // Monitor: pops scan results as the design produces them.
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0) begin
        item_t e;
        logic [31:0] g;
        g = gotQ.pop_front();
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL scoreboard: unexpected result got=%h exp=none", g);
        end else begin
          e = expQ.pop_front();
          if (g !== e.val) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", e.tag, g, e.val);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tckBit(input logic m, input logic d, output logic o);
    tck = 1'b0; tms = m; tdi = d;
    repeat (6) @(posedge clk);
    #1;
    o = tdo;
    tck = 1'b1;
    repeat (6) @(posedge clk);
    #1;
  endtask

  logic oeFirst;

  task automatic shiftIr(input logic [7:0] v);
    logic o;
    logic [7:0] cap;
    tckBit(1, 0, o); tckBit(1, 0, o); tckBit(0, 0, o); tckBit(0, 0, o);
    for (int i = 0; i < 8; i++) begin
      tckBit(i == 7, v[i], o);
      cap[i] = o;
    end
    tckBit(1, 0, o); tckBit(0, 0, o);
    gotQ.push_back({24'd0, cap});
  endtask

  task automatic shiftDr(input int n, input logic [31:0] v);
    logic o;
    logic [31:0] cap;
    cap = '0;
    tckBit(1, 0, o); tckBit(0, 0, o); tckBit(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tck = 1'b0; tms = (i == n - 1); tdi = v[i];
      repeat (6) @(posedge clk);
      #1;
      cap[i] = tdo;
      if (i == 0) oeFirst = tdoOe;
      tck = 1'b1;
      repeat (6) @(posedge clk);
      #1;
    end
    tckBit(1, 0, o); tckBit(0, 0, o);
    gotQ.push_back(cap);
  endtask

  task automatic goIdle();
    logic o;
    for (int i = 0; i < 5; i++) tckBit(1, 0, o);
    tckBit(0, 0, o);
  endtask

  initial begin
    logic o;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 tdoOe in reset", tdoOe, 0);
    chk("R1 requests in reset", {coreResetReq, coreIntReq}, 0);
    chk("R1 bsDrive in reset", bsDrive, 0);
    trstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    tckBit(0, 0, o);
    chk("R3 tdoOe idle", tdoOe, 0);

    // R5: default instruction after reset is IDCODE
    expectScan("R5 idcode after reset", ID_EXP);
    shiftDr(32, 32'h0);
    chk("R3 tdoOe during shift", oeFirst, 1);

    // R4/R6: IR capture and bypass
    expectScan("R4 ir capture 01", 32'h01);
    shiftIr(8'hFF);
    expectScan("R6 bypass shift", 32'h4A);
    shiftDr(8, 32'hA5);
    expectScan("R4 ir capture 01 again", 32'h01);
    shiftIr(8'h77);
    expectScan("R6 unknown code bypass", 32'h66);
    shiftDr(8, 32'h33);

    // R2/R5: TMS reset reselects IDCODE
    goIdle();
    expectScan("R2 tms reset restores idcode", ID_EXP);
    shiftDr(32, 32'h0);

    // R7: sample / preload
    bsPinIn = 8'h3C;
    expectScan("R4 capture before sample", 32'h01);
    shiftIr(8'h20);
    expectScan("R7 sample captures pins", 32'h3C);
    shiftDr(8, 32'h96);
    chk("R7 preload latched", bsPinOut, 8'h96);
    chk("R7 no drive in sample", bsDrive, 0);

    // R8: extest
    expectScan("R4 capture before extest", 32'h01);
    shiftIr(8'h00);
    chk("R8 drive on extest", bsDrive, 1);
    chk("R8 preload on pins", bsPinOut, 8'h96);
    bsPinIn = 8'hC3;
    expectScan("R8 extest captures pins", 32'hC3);
    shiftDr(8, 32'h55);
    chk("R8 update drives new value", bsPinOut, 8'h55);

    // R9: switchover
    expectScan("R9 capture before switch", 32'h01);
    shiftIr(8'h5A);
    chk("R9 boundary drive released", bsDrive, 0);
    tckBit(0, 0, o);
    expectScan("R10 debug ir capture", 32'h01);
    shiftIr(8'h10);
    expectScan("R9 debug dr is bypass not idcode", 32'h4A);
    shiftDr(8, 32'hA5);

    // R10: request pulses
    expectScan("R10 capture before reset req", 32'h01);
    shiftIr(8'h31);
    repeat (4) @(posedge clk);
    #1;
    chk("R10 one reset pulse", rstPulses, 1);
    chk("R10 no int pulse yet", intPulses, 0);
    expectScan("R10 capture before int req", 32'h01);
    shiftIr(8'h32);
    repeat (4) @(posedge clk);
    #1;
    chk("R10 one int pulse", intPulses, 1);
    chk("R10 reset pulses unchanged", rstPulses, 1);

    // R9: TMS reset keeps debug ownership
    goIdle();
    expectScan("R9 debug ir after tms reset", 32'h01);
    shiftIr(8'h10);
    expectScan("R9 still bypass after tms reset", 32'h0);
    shiftDr(32, 32'h0);

    // R11: TRST falls with the TCK rise leaving debug Update-IR
    tckBit(1, 0, o); tckBit(1, 0, o); tckBit(0, 0, o); tckBit(0, 0, o);
    for (int i = 0; i < 8; i++) tckBit(i == 7, 8'h31 >> i, o);
    tckBit(1, 0, o);
    tck = 1'b0; tms = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    tck = 1'b1; trstN = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    trstN = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R11 no reset pulse on collision", rstPulses, 1);
    chk("R1 tdoOe after trst", tdoOe, 0);
    tckBit(0, 0, o);
    expectScan("R1 boundary owns after trst", ID_EXP);
    shiftDr(32, 32'h0);

    repeat (20) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: missing results got=%0d exp=0", expQ.size());
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: got=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule